// File: doc/BRIEF.md
# Operating-System Timer with Four Compare Channels

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on each cycle in which an external prescaler asserts a tick strobe. Four compare channels each hold a 32-bit value. When a tick moves the counter onto a channel's value, the block can latch a sticky status bit for that channel and drive its level interrupt line. Channel 3 can also arm a one-shot system-reset request.

Software uses one 32-bit register port. Each access presents a byte offset. A write is qualified by a strobe, and the read data is a combinational function of the offset. Software can reload the counter at any time, and counting resumes from the loaded value. Interrupts are acknowledged by writing ones to the status register.

Top module: `ostmr_top`

## Requirements
- R1: After reset, every register reads 0, all interrupt lines are low and the reset request is low.
- R2: A write to the count register loads the written value, and later ticks count on from that value.
- R3: Each cycle with the tick strobe high (and no count write) adds one to the counter, and 0xFFFFFFFF wraps to 0. Without a tick the counter holds.
- R4: When a tick moves the counter to a value equal to compare register n (full 32 bits) and enable bit n is 1, status bit n is set at that same clock edge. Interrupt line n equals status bit n.
- R5: A compare hit on a channel whose enable bit is 0 changes neither the status register nor the interrupt lines.
- R6: A write to the status register clears exactly the bits written as 1 that are currently set. Bits written as 0 stay as they are, and their interrupt lines stay as they are.
- R7: The interrupt-enable register stores bits 11:0 of a write. Bits 31:12 always read as 0.
- R8: If bit 0 of the watchdog register is 1 when channel 3 hits, the reset request is high for exactly one cycle and the watchdog register reads 0 afterwards. This happens regardless of the enable bits. With bit 0 at 0, a channel 3 hit gives no pulse and leaves the register unchanged.
- R9: A read from an unmapped or unaligned offset returns 0. A write to one changes no register.
- R10: Byte offsets: compare n at 4·n (0x00–0x0C), count at 0x10, status at 0x14 (bits 3:0 = channels 0–3), watchdog at 0x18 (all 32 bits stored, bit 0 = arm), interrupt enable at 0x1C (bit n = channel n).
- R11: When a count write and a tick fall in the same cycle, the written value is loaded without the increment, and the load itself produces no compare hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe from prescaler |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 4 | Per-channel level interrupt lines |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with its default parameters: four channels, 32-bit data, an 8-bit offset and a 12-bit enable field. With these values the complete register map is reachable. The full-width wrap from 0xFFFFFFFF to 0 can be reached by preloading the counter near the top, so no long run is needed. Watchdog arming, disarming and tick/load collisions can all be driven within a few dozen cycles.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int OFS_COUNT  = 'h10;
  localparam int OFS_STATUS = 'h14;
  localparam int OFS_WDOG   = 'h18;
  localparam int OFS_IENA   = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_WDOG,
    SEL_IENA
  } reg_sel_e;
endpackage

// File: rtl/ostmr_decode.sv
module ostmr_decode
  import ostmr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NUM_CH = 4
) (
  input  logic [AW-1:0]                 addr,
  output reg_sel_e                      sel,
  output logic [$clog2(NUM_CH)-1:0]     ch
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [AW-1:0] MATCH_SPAN = AW'(NUM_CH * 4);

  always_comb begin
    sel = SEL_NONE;
    ch  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < MATCH_SPAN) begin
        sel = SEL_MATCH;
        ch  = addr[2 +: CH_W];
      end else if (addr == AW'(OFS_COUNT)) begin
        sel = SEL_COUNT;
      end else if (addr == AW'(OFS_STATUS)) begin
        sel = SEL_STATUS;
      end else if (addr == AW'(OFS_WDOG)) begin
        sel = SEL_WDOG;
      end else if (addr == AW'(OFS_IENA)) begin
        sel = SEL_IENA;
      end
    end
  end
endmodule

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cnt_inc,
  output logic          adv
);
  logic [DW-1:0] cnt_nxt;

  assign cnt_inc = cnt_q + DW'(1);
  assign adv     = tick_en & ~ld;

  always_comb begin
    cnt_nxt = cnt_q;
    if (ld)       cnt_nxt = ld_val;
    else if (adv) cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R2 / R11: a load takes the written value, even with a tick present
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));
  // R3: a tick steps the counter by exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld) |=> (cnt_q == $past(cnt_q) + DW'(1)));
  // R3: without a tick or load the counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  input  logic [DW-1:0] cnt_inc,
  output logic [DW-1:0] cmp_q,
  output logic          hit
);
  logic [DW-1:0] cmp_nxt;

  always_comb begin
    cmp_nxt = cmp_q;
    if (wr) cmp_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_nxt;
  end

  assign hit = adv & (cnt_inc == cmp_q);
endmodule

// File: rtl/ostmr_ctrl.sv
module ostmr_ctrl #(
  parameter int DW      = 32,
  parameter int NUM_CH  = 4,
  parameter int IE_W    = 12,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic              st_wr,
  input  logic              ie_wr,
  input  logic              wd_wr,
  input  logic [DW-1:0]     wdata,
  output logic [NUM_CH-1:0] st_q,
  output logic [IE_W-1:0]   ie_q,
  output logic [DW-1:0]     wd_q,
  output logic              rst_req_q
);
  logic [NUM_CH-1:0] st_nxt, st_set, st_clr;
  logic [IE_W-1:0]   ie_nxt;
  logic [DW-1:0]     wd_nxt;
  logic              fire;

  assign st_set = hit & ie_q[NUM_CH-1:0];
  assign st_clr = st_wr ? (wdata[NUM_CH-1:0] & st_q) : '0;
  assign fire   = hit[WDOG_CH] & wd_q[0];

  always_comb begin
    st_nxt = (st_q & ~st_clr) | st_set;
    ie_nxt = ie_wr ? wdata[IE_W-1:0] : ie_q;
    if (fire)       wd_nxt = '0;
    else if (wd_wr) wd_nxt = wdata;
    else            wd_nxt = wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      ie_q      <= '0;
      wd_q      <= '0;
      rst_req_q <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      ie_q      <= ie_nxt;
      wd_q      <= wd_nxt;
      rst_req_q <= fire;
    end
  end

  // R5: a status bit may only rise on an enabled hit
  a_r5_no_trace: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit & ie_q[NUM_CH-1:0])) == '0));
  // R6: ones written to status (no coincident hit) leave those bits clear
  a_r6_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && hit == '0) |=> ((st_q & $past(wdata[NUM_CH-1:0])) == '0));
  // R8: the reset request never lasts beyond one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  // R8: the watchdog is disarmed whenever the request is raised
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> (wd_q[0] == 1'b0));
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
  import ostmr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int NUM_CH  = 4,
  parameter int IE_W    = 12,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              rst_req
);
  localparam int CH_W = $clog2(NUM_CH);

  reg_sel_e          sel;
  logic [CH_W-1:0]   ch;
  logic [DW-1:0]     cnt_q, cnt_inc;
  logic              adv;
  logic [DW-1:0]     cmp_q [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] st_q;
  logic [IE_W-1:0]   ie_q;
  logic [DW-1:0]     wd_q;

  ostmr_decode #(.AW(AW), .NUM_CH(NUM_CH)) u_dec (
    .addr (reg_addr),
    .sel  (sel),
    .ch   (ch)
  );

  ostmr_counter #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ld      (reg_wr && sel == SEL_COUNT),
    .ld_val  (reg_wdata),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc),
    .adv     (adv)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    ostmr_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr && sel == SEL_MATCH && ch == CH_W'(gi)),
      .wdata   (reg_wdata),
      .adv     (adv),
      .cnt_inc (cnt_inc),
      .cmp_q   (cmp_q[gi]),
      .hit     (hit[gi])
    );
  end

  ostmr_ctrl #(.DW(DW), .NUM_CH(NUM_CH), .IE_W(IE_W), .WDOG_CH(WDOG_CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .st_wr     (reg_wr && sel == SEL_STATUS),
    .ie_wr     (reg_wr && sel == SEL_IENA),
    .wd_wr     (reg_wr && sel == SEL_WDOG),
    .wdata     (reg_wdata),
    .st_q      (st_q),
    .ie_q      (ie_q),
    .wd_q      (wd_q),
    .rst_req_q (rst_req)
  );

  always_comb begin
    case (sel)
      SEL_MATCH:  reg_rdata = cmp_q[ch];
      SEL_COUNT:  reg_rdata = cnt_q;
      SEL_STATUS: reg_rdata = {{(DW-NUM_CH){1'b0}}, st_q};
      SEL_WDOG:   reg_rdata = wd_q;
      SEL_IENA:   reg_rdata = {{(DW-IE_W){1'b0}}, ie_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = st_q;

  // R4: an interrupt line only rises after an enabled hit on its channel
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq & ~$past(irq) & ~$past(hit & ie_q[NUM_CH-1:0])) == '0));
endmodule

// File: tb/ostmr_top_test.sv
module ostmr_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;
  logic        rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  int rst_pulses = 0;
  logic rd_vld;
  logic done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  ostmr_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries and compares read data
  always begin
    @(negedge clk);
    #5;
    if (rd_vld) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  always @(negedge clk) if (rst_n && rst_req) rst_pulses++;

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic sample_pins(string tag, logic [3:0] exp_irq, logic exp_rst);
    @(negedge clk);
    #5;
    check({tag, " irq"}, {28'd0, irq}, {28'd0, exp_irq});
    check({tag, " rst_req"}, {31'd0, rst_req}, {31'd0, exp_rst});
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; rd_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 offsets
    for (int i = 0; i < 8; i++) rd(8'(i * 4), 32'h0, "R1 reset register");
    sample_pins("R1 reset", 4'h0, 1'b0);

    // R2 load, R3 count and hold
    wr(8'h10, 32'h0000_1000);
    rd(8'h10, 32'h0000_1000, "R2 count load");
    ticks(3);
    rd(8'h10, 32'h0000_1003, "R3 three ticks");
    rd(8'h10, 32'h0000_1003, "R3 hold without tick");

    // R7 enable width
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0000_0FFF, "R7 enable upper bits dropped");
    wr(8'h1C, 32'h0000_0001);

    // R4 enabled hit, R5 disabled hit, R10 compare offsets
    wr(8'h00, 32'h0000_1005);
    wr(8'h04, 32'h0000_1005);
    rd(8'h04, 32'h0000_1005, "R10 compare1 readback");
    ticks(2);
    rd(8'h14, 32'h0000_0001, "R4 R5 status after hit");
    sample_pins("R4 R5 hit", 4'h1, 1'b0);

    // R6 write-one-to-clear
    wr(8'h14, 32'h0000_000E);
    rd(8'h14, 32'h0000_0001, "R6 zeros keep bit");
    sample_pins("R6 kept", 4'h1, 1'b0);
    wr(8'h14, 32'h0000_0001);
    rd(8'h14, 32'h0000_0000, "R6 cleared");
    sample_pins("R6 cleared", 4'h0, 1'b0);

    // R3 wrap with hit at zero
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h08, 32'h0000_0000);
    wr(8'h1C, 32'h0000_0004);
    ticks(2);
    rd(8'h10, 32'h0000_0000, "R3 wrap to zero");
    rd(8'h14, 32'h0000_0004, "R4 hit at wrap");
    sample_pins("R4 wrap", 4'h4, 1'b0);
    wr(8'h14, 32'h0000_0004);

    // R8 watchdog armed, enables off
    wr(8'h1C, 32'h0000_0000);
    wr(8'h0C, 32'h0000_0020);
    wr(8'h18, 32'h0000_0001);
    wr(8'h10, 32'h0000_001E);
    ticks(2);
    rd(8'h18, 32'h0000_0000, "R8 watchdog cleared");
    check("R8 one pulse", 32'(rst_pulses), 32'd1);
    rd(8'h14, 32'h0000_0000, "R5 no status with enable off");

    // R8 disarmed pattern, R10 full width stored
    wr(8'h18, 32'hABCD_0000);
    rd(8'h18, 32'hABCD_0000, "R10 watchdog readback");
    wr(8'h10, 32'h0000_001E);
    ticks(2);
    check("R8 no pulse when disarmed", 32'(rst_pulses), 32'd1);
    rd(8'h18, 32'hABCD_0000, "R8 watchdog unchanged");

    // R9 unmapped access
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R9 unmapped read");
    rd(8'h02, 32'h0, "R9 unaligned read");
    rd(8'h00, 32'h0000_1005, "R9 compare0 intact");
    rd(8'h04, 32'h0000_1005, "R9 compare1 intact");
    rd(8'h08, 32'h0000_0000, "R9 compare2 intact");
    rd(8'h0C, 32'h0000_0020, "R9 compare3 intact");
    rd(8'h10, 32'h0000_0020, "R9 count intact");
    rd(8'h14, 32'h0000_0000, "R9 status intact");
    rd(8'h1C, 32'h0000_0000, "R9 enable intact");

    // R11 load with coincident tick
    wr(8'h00, 32'h0000_0050);
    wr(8'h1C, 32'h0000_0001);
    @(negedge clk);
    reg_addr = 8'h10; reg_wdata = 32'h0000_0050; reg_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(8'h10, 32'h0000_0050, "R11 load wins over tick");
    rd(8'h14, 32'h0000_0000, "R11 load gives no hit");
    ticks(1);
    rd(8'h10, 32'h0000_0051, "R11 R2 counting resumes");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule